// File: doc/BRIEF.md
# Streaming TLP Receive Sink

This block sits on the application side of a packet stream coming out of a PCIe transaction layer. Each beat carries a data word, start and end markers, a valid strobe, an error strobe for uncorrectable errors in the upstream receive buffer, and an 8-bit one-hot vector that says which base address register (BAR) the packet hit. The sink tells the source when it may send. It classifies every packet from the type field of its first header dword. It captures the BAR vector on the first beat only. It then forwards whole packets, beat by beat, to a FIFO-style consumer, with each beat tagged with the packet class, the BAR index and an error flag.

The source does not stop at once when ready falls. It may keep sending for two more clocks. A small skid queue therefore stores every accepted beat, and ready is withdrawn early enough that the queue can never overflow. A two-state machine tracks packet framing:

- `ST_IDLE` waits for a start beat.
- `ST_BODY` is inside a multi-beat packet.

The transitions are:

- `IDLE_TO_BODY` on a valid start beat without end.
- `BODY_TO_IDLE` on a valid end beat.
- `IDLE_SINGLE` is a self-loop on a valid beat with both start and end set.
- `IDLE_STRAY` is a self-loop on a valid beat without start, which is discarded.
- `BODY_HOLD` is a self-loop on any other beat.

Any accepted beat whose error strobe is high also sets a sticky error status, which a clear pulse resets.

Top module: `tlp_rx_sink`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `err_sticky` is 0.
- R2: Every stored beat appears on the output in arrival order, with `out_data`, `out_sop` and `out_eop` equal to the values it had at the input. A cycle with `in_valid` low carries no beat, whatever the other inputs show.
- R3: The BAR vector is taken only from the start beat of a packet. All beats of that packet carry the same class and BAR tag, whatever `in_bar` shows on later beats.
- R4: The packet type is `in_data[28:24]` of the start beat. Memory (`00000`, `00001`) and IO (`00010`) packets are BAR-routed. Every other type is tagged class 1 (no BAR) with `out_hit` = 0, and its BAR vector is ignored.
- R5: The class of a BAR-routed packet depends on its BAR vector. If exactly one of bits 0..5 is set and bits 6..7 are clear, the class is 0 (hit) and `out_hit` is that bit index. Otherwise the class is 2 (unmatched) and `out_hit` is 0. Class 3 never appears.
- R6: `in_ready` is low exactly when 2 or fewer entries of the skid queue are free.
- R7: Beats that arrive in the first two cycles after `in_ready` falls are stored and forwarded. None is lost and the queue never overflows.
- R8: `out_err` of a beat is 1 if and only if some beat of the same packet, up to and including this one, had `in_err` high. Clean packets show 0 on every beat.
- R9: `err_sticky` is set in the cycle after a stored beat with `in_err` high. It stays set until `err_clr` is pulsed, and a new error beat wins over a clear in the same cycle.
- R10: A valid beat without start that arrives outside a packet is discarded. It is not forwarded, and its error strobe does not set `err_sticky`.
- R11: A packet of a single beat, with start and end in the same cycle, is forwarded and tagged like a longer one.
- R12: While `out_valid` is high and `out_ready` is low, the output beat and all of its tags hold steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat present on the input |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_err | input | 1 | Uncorrectable buffer error on this beat |
| in_bar | input | BAR_W | One-hot BAR hit vector, meaningful on the start beat |
| in_data | input | DATA_W | Beat data; header dword 0 in bits 31:0 |
| in_ready | output | 1 | Sink can take more beats |
| out_valid | output | 1 | Beat available to the consumer |
| out_ready | input | 1 | Consumer takes the beat |
| out_data | output | DATA_W | Forwarded data |
| out_sop | output | 1 | Forwarded start marker |
| out_eop | output | 1 | Forwarded end marker |
| out_err | output | 1 | Packet has seen an error so far |
| out_cls | output | 2 | 0 hit, 1 no BAR, 2 unmatched |
| out_hit | output | 3 | BAR index when class is 0 |
| err_clr | input | 1 | Clear pulse for the sticky error |
| err_sticky | output | 1 | Sticky error status |

## Verification
Directed packets are mixed with random ones. The directed set covers a single-beat memory read to the highest BAR and a completion whose BAR vector is set, which must be ignored. It also covers IO and memory packets with a reserved bit, with two bits and with no bit set, and a message. Together these separate a correct type filter from one that trusts the vector, and a one-hot check from a plain priority encoder. A multi-beat packet with the error only on its last beat shows whether the flag accumulates rather than being latched at the start. A stray beat carrying an error shows whether framing filters beats before they can reach the queue or the sticky bit. The random traffic draws BAR vectors that differ between the start beat and later beats, so a design that samples the vector late is caught. A randomly stalling consumer, and a source that uses its two-beat grace window every time ready falls, drive the queue to full and test the ready threshold and the loss-free skid.

// File: rtl/tlp_sink_pkg.sv
package tlp_sink_pkg;
    localparam int HIT_W = 3;

    typedef enum logic [1:0] {
        CLS_HIT       = 2'd0,
        CLS_NOBAR     = 2'd1,
        CLS_UNMATCHED = 2'd2
    } pkt_cls_e;

    typedef struct packed {
        logic             sop;
        logic             eop;
        logic             err;
        pkt_cls_e         cls;
        logic [HIT_W-1:0] hit;
    } beat_tag_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BODY = 1'b1
    } rx_state_e;
endpackage

// File: rtl/tlp_sink_class.sv
module tlp_sink_class
    import tlp_sink_pkg::*;
#(
    parameter int BAR_W   = 8,
    parameter int NUM_BAR = 6
) (
    input  logic [4:0]       pkt_type,
    input  logic [BAR_W-1:0] bar,
    output pkt_cls_e         cls,
    output logic [HIT_W-1:0] hit
);
    localparam int CNT_W = $clog2(NUM_BAR + 1);

    logic             routed;
    logic             rsv_set;
    logic [CNT_W-1:0] ones;
    logic [HIT_W-1:0] idx;

    assign routed  = (pkt_type[4:1] == 4'b0000) || (pkt_type == 5'b00010);
    assign rsv_set = |bar[BAR_W-1:NUM_BAR];

    always_comb begin
        ones = '0;
        idx  = '0;
        for (int i = 0; i < NUM_BAR; i++) begin
            if (bar[i]) begin
                ones = ones + CNT_W'(1);
                idx  = HIT_W'(i);
            end
        end
    end

    always_comb begin
        if (!routed) begin
            cls = CLS_NOBAR;
            hit = '0;
        end else if (rsv_set || ones != CNT_W'(1)) begin
            cls = CLS_UNMATCHED;
            hit = '0;
        end else begin
            cls = CLS_HIT;
            hit = idx;
        end
    end
endmodule

// File: rtl/tlp_sink_skid.sv
module tlp_sink_skid #(
    parameter int W     = 73,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               rdata,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic          do_pop;

    assign empty  = (count == '0);
    assign do_pop = pop && !empty;
    assign rdata  = mem[rp_q];

    always_ff @(posedge clk) begin
        if (push) mem[wp_q] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            count <= '0;
        end else begin
            if (push)   wp_q <= (wp_q == LAST) ? '0 : wp_q + AW'(1);
            if (do_pop) rp_q <= (rp_q == LAST) ? '0 : rp_q + AW'(1);
            count <= count + CW'(push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/tlp_rx_sink.sv
module tlp_rx_sink
    import tlp_sink_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int BAR_W   = 8,
    parameter int NUM_BAR = 6,
    parameter int DEPTH   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_err,
    input  logic [BAR_W-1:0]  in_bar,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_err,
    output logic [1:0]        out_cls,
    output logic [2:0]        out_hit,
    input  logic              err_clr,
    output logic              err_sticky
);
    localparam int TAG_W    = $bits(beat_tag_t);
    localparam int ENT_W    = DATA_W + TAG_W;
    localparam int CW       = $clog2(DEPTH + 1);
    localparam int TYPE_LSB = 24;
    localparam logic [CW-1:0] RDY_LIM = CW'(DEPTH - 3);

    rx_state_e        st_q, st_d;
    pkt_cls_e         cls_q, cls_now;
    logic [HIT_W-1:0] hit_q, hit_now;
    logic             perr_q;
    logic             push;
    beat_tag_t        push_tag, pop_tag;
    logic [DATA_W-1:0] pop_data;
    logic             q_empty;
    logic [CW-1:0]    q_count;

    tlp_sink_class #(.BAR_W(BAR_W), .NUM_BAR(NUM_BAR)) u_class (
        .pkt_type (in_data[TYPE_LSB +: 5]),
        .bar      (in_bar),
        .cls      (cls_now),
        .hit      (hit_now)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (in_valid && in_sop && !in_eop) st_d = ST_BODY; // IDLE_TO_BODY
            ST_BODY: if (in_valid && in_eop)            st_d = ST_IDLE; // BODY_TO_IDLE
            default: st_d = ST_IDLE;
        endcase
    end

    // outputs of the machine: push strobe and tag of the beat
    always_comb begin
        push     = 1'b0;
        push_tag = '0;
        unique case (st_q)
            ST_IDLE: begin
                push         = in_valid && in_sop;  // stray beats dropped
                push_tag.cls = cls_now;
                push_tag.hit = hit_now;
                push_tag.err = in_err;
            end
            ST_BODY: begin
                push         = in_valid;
                push_tag.cls = cls_q;
                push_tag.hit = hit_q;
                push_tag.err = perr_q || in_err;
            end
            default: push = 1'b0;
        endcase
        push_tag.sop = in_sop;
        push_tag.eop = in_eop;
    end

    // per-packet context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q  <= CLS_NOBAR;
            hit_q  <= '0;
            perr_q <= 1'b0;
        end else if (push) begin
            cls_q  <= push_tag.cls;
            hit_q  <= push_tag.hit;
            perr_q <= push_tag.err;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                 err_sticky <= 1'b0;
        else if (push && in_err)    err_sticky <= 1'b1;
        else if (err_clr)           err_sticky <= 1'b0;
    end

    tlp_sink_skid #(.W(ENT_W), .DEPTH(DEPTH)) u_skid (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata ({in_data, push_tag}),
        .pop   (out_ready),
        .rdata ({pop_data, pop_tag}),
        .empty (q_empty),
        .count (q_count)
    );

    assign in_ready  = (q_count <= RDY_LIM);
    assign out_valid = !q_empty;
    assign out_data  = pop_data;
    assign out_sop   = pop_tag.sop;
    assign out_eop   = pop_tag.eop;
    assign out_err   = pop_tag.err;
    assign out_cls   = pop_tag.cls;
    assign out_hit   = pop_tag.hit;
endmodule

// File: rtl/tlp_rx_sink_chk.sv
module tlp_rx_sink_chk
    import tlp_sink_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic                       in_eop,
    input logic                       out_valid,
    input logic                       out_ready,
    input logic [DATA_W-1:0]          out_data,
    input logic                       out_sop,
    input logic                       out_eop,
    input logic                       out_err,
    input logic [1:0]                 out_cls,
    input logic [2:0]                 out_hit,
    input logic                       err_clr,
    input logic                       err_sticky,
    input rx_state_e                  st_q,
    input pkt_cls_e                   cls_q,
    input logic [HIT_W-1:0]           hit_q,
    input logic                       perr_q,
    input logic [$clog2(DEPTH+1)-1:0] q_count,
    input logic                       push
);
    localparam int CW = $clog2(DEPTH + 1);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == CW'(DEPTH)) |-> !push);

    assert_out_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
            && $stable({out_sop, out_eop, out_err, out_cls, out_hit})));

    assert_bar_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BODY && !(in_valid && in_eop)) |=> ($stable(cls_q) && $stable(hit_q)));

    assert_err_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BODY && perr_q && !(in_valid && in_eop)) |=> perr_q);

    assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_sticky && !err_clr) |=> err_sticky);

    assert_nobar_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_cls != 2'd0) |-> (out_hit == 3'd0));

    assert_cls_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_cls != 2'd3));
endmodule

bind tlp_rx_sink tlp_rx_sink_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_eop     (in_eop),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_sop    (out_sop),
    .out_eop    (out_eop),
    .out_err    (out_err),
    .out_cls    (out_cls),
    .out_hit    (out_hit),
    .err_clr    (err_clr),
    .err_sticky (err_sticky),
    .st_q       (st_q),
    .cls_q      (cls_q),
    .hit_q      (hit_q),
    .perr_q     (perr_q),
    .q_count    (q_count),
    .push       (push)
);

// File: tb/test_tlp_rx_sink.sv
module test_tlp_rx_sink;
    localparam int DATA_W = 64;
    localparam int DEPTH  = 4;
    localparam int LIMIT  = 150000;

    typedef struct {
        logic [DATA_W-1:0] data;
        logic sop, eop, err, stray;
        logic [7:0] bar;
        logic [1:0] ecls;
        logic [2:0] ehit;
        logic eerr;
    } stim_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 0, in_sop = 0, in_eop = 0, in_err = 0;
    logic [7:0] in_bar = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic in_ready, out_valid, out_ready = 0;
    logic [DATA_W-1:0] out_data;
    logic out_sop, out_eop, out_err;
    logic [1:0] out_cls;
    logic [2:0] out_hit;
    logic err_clr = 0, err_sticky;

    always #4 clk = ~clk;

    tlp_rx_sink #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_tlp_rx_sink (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_err(in_err), .in_bar(in_bar), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
        .out_err(out_err), .out_cls(out_cls), .out_hit(out_hit),
        .err_clr(err_clr), .err_sticky(err_sticky)
    );

    int checks = 0, errors = 0, cyc = 0, occ = 0, low_run = 0;
    logic sticky_m = 0;
    logic timeout = 0;
    stim_t sq[$];
    stim_t eq[$];

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic void exp_tag(input logic [4:0] typ, input logic [7:0] bar,
                                    output logic [1:0] cls, output logic [2:0] hit);
        int n;
        n = 0;
        hit = 3'd0;
        for (int i = 0; i < 6; i++) if (bar[i]) n++;
        if (!(typ == 5'b00000 || typ == 5'b00001 || typ == 5'b00010)) begin
            cls = 2'd1;
        end else if (bar[7:6] != 2'b00 || n != 1) begin
            cls = 2'd2;
        end else begin
            cls = 2'd0;
            for (int i = 0; i < 6; i++) if (bar[i]) hit = 3'(i);
        end
    endfunction

    task automatic gen_pkt(input logic [4:0] typ, input logic [7:0] bar, input int len,
                           input logic [7:0] errmask);
        logic [1:0] c;
        logic [2:0] h;
        logic acc;
        exp_tag(typ, bar, c, h);
        acc = 1'b0;
        for (int b = 0; b < len; b++) begin
            stim_t s;
            s.data  = {$urandom, $urandom};
            if (b == 0) s.data[28:24] = typ;
            s.sop   = (b == 0);
            s.eop   = (b == len - 1);
            s.err   = errmask[b];
            s.stray = 1'b0;
            s.bar   = (b == 0) ? bar : 8'($urandom);
            acc     = acc | s.err;
            s.ecls  = c;
            s.ehit  = h;
            s.eerr  = acc;
            sq.push_back(s);
        end
    endtask

    task automatic gen_stray(input logic err);
        stim_t s;
        s.data = {$urandom, $urandom};
        s.sop = 1'b0; s.eop = 1'($urandom); s.err = err; s.stray = 1'b1;
        s.bar = 8'($urandom); s.ecls = '0; s.ehit = '0; s.eerr = 1'b0;
        sq.push_back(s);
    endtask

    task automatic step();
        logic rdy, allowed, send, clr, pushed_err;
        stim_t s;
        @(negedge clk);
        cyc++;
        if (cyc > LIMIT) timeout = 1'b1;
        // R6: ready follows free space of the queue
        check(in_ready === (occ <= DEPTH - 3), "R6 ready", 64'(in_ready), 64'(occ <= DEPTH - 3));
        // R9: sticky error status
        check(err_sticky === sticky_m, "R9 sticky", 64'(err_sticky), 64'(sticky_m));
        // consumer
        rdy = (($urandom % 100) < 65);
        out_ready = rdy;
        if (out_valid && rdy) begin
            if (eq.size() == 0) begin
                check(1'b0, "R10 unexpected beat", out_data, 64'd0);
            end else begin
                s = eq.pop_front();
                check(out_data === s.data, "R2 data", out_data, s.data);
                check({out_sop, out_eop} === {s.sop, s.eop}, "R2 framing", {out_sop, out_eop}, {s.sop, s.eop});
                check(out_cls === s.ecls, "R4 R5 class", 64'(out_cls), 64'(s.ecls));
                check(out_hit === s.ehit, "R3 R5 hit", 64'(out_hit), 64'(s.ehit));
                check(out_err === s.eerr, "R8 err", 64'(out_err), 64'(s.eerr));
                if (s.sop && s.eop) check(out_cls === s.ecls, "R11 single", 64'(out_cls), 64'(s.ecls));
            end
            occ--;
        end
        // source with a two-cycle grace after ready falls (R7)
        if (in_ready) low_run = 0;
        allowed = in_ready || (low_run < 2);
        if (!in_ready) low_run++;
        send = allowed && (sq.size() > 0) && (!in_ready || (($urandom % 100) < 80));
        pushed_err = 1'b0;
        if (send) begin
            s = sq.pop_front();
            in_valid = 1'b1; in_sop = s.sop; in_eop = s.eop; in_err = s.err;
            in_bar = s.bar; in_data = s.data;
            if (!s.stray) begin
                eq.push_back(s);
                occ++;
                pushed_err = s.err;
            end
        end else begin
            // R2: junk on idle cycles must be ignored
            in_valid = 1'b0; in_sop = 1'($urandom); in_eop = 1'($urandom);
            in_err = 1'($urandom); in_bar = 8'($urandom); in_data = {$urandom, $urandom};
        end
        clr = (($urandom % 100) < 4);
        err_clr = clr;
        if (pushed_err) sticky_m = 1'b1;
        else if (clr)   sticky_m = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready === 1'b1, "R1 ready", 64'(in_ready), 64'd1);
        check(out_valid === 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
        check(err_sticky === 1'b0, "R1 sticky", 64'(err_sticky), 64'd0);

        // directed corners
        gen_pkt(5'b00000, 8'h20, 1, 8'h00);  // R11 single beat, BAR5
        gen_pkt(5'b01010, 8'h01, 2, 8'h00);  // R4 completion, vector ignored
        gen_pkt(5'b00010, 8'h40, 2, 8'h00);  // R5 reserved bit
        gen_pkt(5'b00000, 8'h06, 3, 8'h00);  // R5 two bits
        gen_pkt(5'b00001, 8'h00, 1, 8'h00);  // R5 no bit
        gen_pkt(5'b10000, 8'h04, 3, 8'h00);  // R4 message
        gen_pkt(5'b00000, 8'h08, 4, 8'h08);  // R8 error on last beat only
        gen_stray(1'b1);                     // R10 stray beat with error
        gen_pkt(5'b00010, 8'h02, 2, 8'h00);
        for (int p = 0; p < 300; p++) begin
            logic [4:0] typ;
            logic [7:0] bar;
            int k;
            k = $urandom % 8;
            case (k)
                0: typ = 5'b00000; 1: typ = 5'b00001; 2: typ = 5'b00010;
                3: typ = 5'b01010; 4: typ = 5'b10011; 5: typ = 5'b00100;
                default: typ = 5'b00000;
            endcase
            if (($urandom % 4) != 0) bar = 8'h01 << ($urandom % 6);
            else bar = 8'($urandom);
            if (($urandom % 10) == 0) gen_stray(1'($urandom));
            gen_pkt(typ, bar, 1 + ($urandom % 5), (($urandom % 6) == 0) ? 8'(1 << ($urandom % 5)) : 8'h00);
        end

        while ((sq.size() > 0 || eq.size() > 0) && !timeout) step();
        repeat (4) if (!timeout) step();
        if (timeout) check(1'b0, "watchdog", 64'(cyc), 64'(LIMIT));
        check(eq.size() == 0, "R7 all beats delivered", 64'(eq.size()), 64'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule